// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor port and a main-memory port and keeps a one-word-per-entry copy of recently read memory words. A 15-bit word address is split into a 9-bit set index (the low bits) and a 6-bit tag (the high bits). The index picks exactly one of 512 entries. Each entry holds a valid flag, a tag and a 12-bit data word. A read whose index entry is valid and carries the same tag is served from the entry. Any other read fetches the word from memory, installs it in that entry and returns it.

Writes always go to memory. A write that hits also updates the entry in the same cycle it is accepted. A write that misses leaves the cache contents untouched and does not allocate an entry. Two counters record hits and misses so that a hit ratio can be derived from them.

The controller is a three-state machine:
- `ST_IDLE` accepts requests and serves read hits.
- `ST_FETCH` waits on a memory read for a miss.
- `ST_WRITE` waits on a memory write.

Its transitions are:
- IDLE→FETCH on an accepted read that misses.
- IDLE→WRITE on any accepted write.
- IDLE→IDLE on an accepted read hit, or when no request is accepted.
- FETCH→IDLE and WRITE→IDLE on the memory acknowledge.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `mem_req` is 0, both counters are 0, and every entry is invalid, so the first read of any address misses.
- R2: Index is `cpu_addr[8:0]` and tag is `cpu_addr[14:9]`. Two addresses with the same index but different tags occupy the same entry, so reading one evicts the other.
- R3: A request is accepted on a clock edge where `cpu_req` and `cpu_ready` are both 1. A read hit returns the stored word with `cpu_done` high in the cycle right after acceptance. It makes no memory access and adds 1 to `hit_count`.
- R4: A read miss issues one memory read with the full 15-bit address. It returns the word delivered by memory with `cpu_done`, and installs that word and the new tag so that the next read of the address hits. It adds 1 to `miss_count`.
- R5: A write hit updates the entry and issues one memory write carrying the address and data. A later read of the address returns the new data as a hit. It adds 1 to `hit_count`.
- R6: A write miss issues one memory write only. The entry keeps its previous contents: the written address still misses on a later read, and the previous occupant of the index still hits. It adds 1 to `miss_count`.
- R7: `cpu_ready` is 0 from the cycle after a miss or a write is accepted until the memory acknowledge is taken. In the following cycle, `cpu_ready` and `cpu_done` are both 1.
- R8: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Word address (tag 14:9, index 8:0) |
| cpu_wdata | input | 12 | Write data |
| cpu_ready | output | 1 | Controller idle; a request is taken when both strobes are high |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 12 | Read result, valid with `cpu_done` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| hit_count | output | 16 | Number of hits since reset |
| miss_count | output | 16 | Number of misses since reset |

## Verification
The hardest case to reach is a write miss on an index already held by another tag. It needs the index first filled by a read and then written under a different tag. The check must then show that the resident tag still hits and the written address still misses. Random traffic hits this only rarely, so the stimulus limits addresses to four tags over eight indices, which makes such collisions frequent. A directed fill/write-miss/read sequence also forces the case once. Memory latency varies randomly from zero to three extra cycles, which exercises the hold of the memory request while the acknowledge is pending.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } ctl_state_e;

    typedef enum int unsigned {
        EV_HIT  = 0,
        EV_MISS = 1
    } event_e;

    localparam int unsigned NUM_EVENTS = 2;
endpackage

// File: rtl/dmc_store.sv
module dmc_store #(
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_mem  [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];

    // valid flags reset; tag/data arrays need no reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        lk_data = data_mem[lk_idx];
        lk_hit  = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
    end

    AST_WRITE_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_mem[$past(wr_idx)] == $past(wr_tag)
                   && data_mem[$past(wr_idx)] == $past(wr_data))); // R4
endmodule

// File: rtl/dmc_perf.sv
module dmc_perf
    import dmc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] ev_inc,
    output logic [CNT_W-1:0]      ev_cnt [NUM_EVENTS]
);
    for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ev_cnt[g] <= '0;
            end else if (ev_inc[g]) begin
                ev_cnt[g] <= ev_cnt[g] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            AST_ONE_EVENT: assert ($countones(ev_inc) <= 1); // R3
        end
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned ADDR_W = TAG_W + IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic                  cpu_ready,
    output logic                  cpu_done,
    output logic [DATA_W-1:0]     cpu_rdata,
    input  logic                  lk_hit,
    input  logic [DATA_W-1:0]     lk_data,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      wr_idx,
    output logic [TAG_W-1:0]      wr_tag,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic                  mem_ack,
    output logic [NUM_EVENTS-1:0] ev_inc
);
    ctl_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              accept;

    assign accept = cpu_req && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cpu_we)       state_d = ST_WRITE;
                    else if (!lk_hit) state_d = ST_FETCH;
                end
            end
            ST_FETCH: if (mem_ack) state_d = ST_IDLE;
            ST_WRITE: if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = cpu_addr[IDX_W-1:0];
        wr_tag    = cpu_addr[ADDR_W-1:IDX_W];
        wr_data   = cpu_wdata;
        ev_inc    = '0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                if (accept) begin
                    ev_inc[EV_HIT]  = lk_hit;
                    ev_inc[EV_MISS] = !lk_hit;
                    wr_en           = cpu_we && lk_hit;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                wr_en   = mem_ack;
                wr_idx  = addr_q[IDX_W-1:0];
                wr_tag  = addr_q[ADDR_W-1:IDX_W];
                wr_data = mem_rdata;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

    // request capture and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
                if (!cpu_we && lk_hit) begin
                    rdata_q <= lk_data;
                    done_q  <= 1'b1;
                end
            end
            if (state_q == ST_FETCH && mem_ack) begin
                rdata_q <= mem_rdata;
                done_q  <= 1'b1;
            end
            if (state_q == ST_WRITE && mem_ack) begin
                done_q <= 1'b1;
            end
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R8
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (cpu_ready && cpu_done)); // R7
    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && lk_hit) |=> (!mem_req && cpu_done)); // R3
    AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && !lk_hit) |=>
            (mem_req && !mem_we && !cpu_ready && mem_addr == $past(cpu_addr))); // R4
    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we) |=>
            (mem_req && mem_we && mem_wdata == $past(cpu_wdata))); // R5
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    logic                  lk_hit;
    logic [DATA_W-1:0]     lk_data;
    logic                  wr_en;
    logic [IDX_W-1:0]      wr_idx;
    logic [TAG_W-1:0]      wr_tag;
    logic [DATA_W-1:0]     wr_data;
    logic [NUM_EVENTS-1:0] ev_inc;
    logic [CNT_W-1:0]      ev_cnt [NUM_EVENTS];

    dmc_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (cpu_addr[IDX_W-1:0]),
        .lk_tag  (cpu_addr[ADDR_W-1:IDX_W]),
        .lk_hit  (lk_hit),
        .lk_data (lk_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .wr_data (wr_data)
    );

    dmc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_done  (cpu_done),
        .cpu_rdata (cpu_rdata),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .ev_inc    (ev_inc)
    );

    dmc_perf #(.CNT_W(CNT_W)) u_perf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_inc (ev_inc),
        .ev_cnt (ev_cnt)
    );

    assign hit_count  = ev_cnt[EV_HIT];
    assign miss_count = ev_cnt[EV_MISS];

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpu_ready && !mem_req)); // R1
endmodule

// File: tb/dm_wt_cache_tb.sv
module dm_wt_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [11:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_done;
    logic [11:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] hit_count, miss_count;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    int n_rd = 0, n_wr = 0;
    logic [14:0] last_addr = '0;
    logic [11:0] last_wdata = '0;
    int wait_cnt = 0;
    int exp_hits = 0, exp_misses = 0;

    logic [11:0] mem_model [int];
    bit          ref_valid [512];
    logic [5:0]  ref_tag   [512];

    always #10 clk = ~clk;

    dm_wt_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .hit_count(hit_count),
        .miss_count(miss_count)
    );

    function automatic logic [11:0] mem_get(input logic [14:0] a);
        if (mem_model.exists(int'(a))) return mem_model[int'(a)];
        return 12'((int'(a) * 37 + 5) & 12'hFFF);
    endfunction

    // memory responder with random latency
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req && rst_n) begin
            if (wait_cnt == 0) begin
                mem_ack <= 1'b1;
                last_addr = mem_addr;
                if (mem_we) begin
                    mem_model[int'(mem_addr)] = mem_wdata;
                    last_wdata = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata <= mem_get(mem_addr);
                    n_rd++;
                end
                wait_cnt <= int'($urandom_range(0, 3));
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one processor access with full checking against the reference model
    task automatic access(input bit we, input logic [14:0] addr, input logic [11:0] wd);
        int idx = int'(addr[8:0]);
        bit hit = ref_valid[idx] && (ref_tag[idx] == addr[14:9]);
        logic [11:0] exp_rd = mem_get(addr);
        int rd0 = n_rd, wr0 = n_wr, lat = 1;
        string rq = we ? (hit ? "R5" : "R6") : (hit ? "R3" : "R4");
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        check("R7", "ready after accept", int'(cpu_ready), int'(!we && hit));
        while (!cpu_done && lat < 60) begin @(negedge clk); lat++; end
        check(rq, "done seen", int'(cpu_done), 1);
        if (!we) begin
            check(rq, "read data", int'(cpu_rdata), int'(exp_rd));
            if (hit) begin
                check("R3", "hit latency", lat, 1);
                check("R3", "no mem traffic", n_rd + n_wr, rd0 + wr0);
            end else begin
                check("R4", "one mem read", n_rd, rd0 + 1);
                check("R4", "fetch address", int'(last_addr), int'(addr));
                ref_valid[idx] = 1'b1;
                ref_tag[idx]   = addr[14:9];
            end
        end else begin
            check(rq, "one mem write", n_wr, wr0 + 1);
            check(rq, "no mem read", n_rd, rd0);
            check(rq, "write address", int'(last_addr), int'(addr));
            check(rq, "write data", int'(last_wdata), int'(wd));
        end
        if (hit) exp_hits++; else exp_misses++;
        check("R7", "ready at done", int'(cpu_ready), 1);
        check(rq, "hit_count", int'(hit_count), exp_hits);
        check(rq, "miss_count", int'(miss_count), exp_misses);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 512; i++) begin ref_valid[i] = 1'b0; ref_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "ready", int'(cpu_ready), 1);
        check("R1", "mem_req", int'(mem_req), 0);
        check("R1", "hit_count", int'(hit_count), 0);
        check("R1", "miss_count", int'(miss_count), 0);
        // R1/R4: first reads miss, including address corners
        access(1'b0, 15'h0000, '0);
        access(1'b0, 15'h7FFF, '0);
        access(1'b0, 15'h0000, '0);   // R3 hit
        access(1'b0, 15'h7FFF, '0);   // R3 hit
        // R2: same index, other tag evicts
        access(1'b0, 15'h0200, '0);   // index 0, tag 1: miss
        access(1'b0, 15'h0000, '0);   // evicted: miss
        check("R2", "eviction misses", exp_misses, 4);
        // R5: write hit then read returns new data as hit
        access(1'b1, 15'h0000, 12'hABC);
        access(1'b0, 15'h0000, '0);
        check("R5", "read-after-write data", int'(cpu_rdata), 12'hABC);
        // R6: write miss does not allocate
        access(1'b1, 15'h0400, 12'h5A5); // index 0, tag 2: miss
        access(1'b0, 15'h0000, '0);      // resident tag still hits
        check("R6", "resident hit", int'(hit_count), exp_hits);
        access(1'b0, 15'h0400, '0);      // still misses, returns written word
        check("R6", "written word from memory", int'(cpu_rdata), 12'h5A5);
        // random mix over four tags and eight indices
        for (int k = 0; k < 600; k++) begin
            logic [14:0] a;
            a = {4'h0, 2'($urandom_range(0, 3)), 6'h00, 3'($urandom_range(0, 7))};
            access(1'($urandom_range(0, 2) == 0), a, 12'($urandom));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule